// File: doc/BRIEF.md
# Dual-Clock FIFO with Programmable Flags

A first-in first-out buffer with nine-bit words and a power-of-two depth chosen by parameter, from 64 up to 4096 entries. The producer and the consumer run on separate, unrelated clocks. Each side converts its own position in the store to Gray code. That code crosses to the other side through a two-stage synchronizer. Every flag is therefore registered in the domain that consumes it. All four status outputs are active low: empty and almost-empty belong to the read clock, and full and almost-full belong to the write clock.

While reset is held low, the block samples the second write-enable/load input on the write clock and keeps that value as its operating mode. With the input high, the pin acts as a second, active-high write enable. With the input low, the block runs in programmable-flag mode. In that mode a write cycle with the load pin low is not stored. It raises a strobe instead, which goes to the separate offset-loading block. That block supplies the two almost-flag thresholds, and they default to 7. Output-enable does not tri-state the bus in this model. It drives a valid qualifier beside the data.

Top module: `dcf_pflag_top`

## Requirements
- R1: A word is stored on a rising write-clock edge when `wen1_n` is low, `wen2_ld` is high and `full_n` is high, in either mode.
- R2: On a rising read-clock edge with `ren1_n` and `ren2_n` both low and `empty_n` high, the oldest stored word moves to `rdata_o`. Words leave in the order they were stored.
- R3: While either read enable is high, `rdata_o` keeps its previous value.
- R4: `full_n` is low when the store holds `DEPTH` words, and write cycles are then ignored.
- R5: `empty_n` is low when the store holds no word, and read cycles are then ignored.
- R6: While reset is low, `empty_n` and `aempty_n` are low, `full_n` and `afull_n` are high, and `rdata_o` is zero. Both positions return to the first entry.
- R7: Once both sides are idle, `aempty_n` is low exactly when the stored count is at most `ae_ofs_i`.
- R8: Once both sides are idle, `afull_n` is low exactly when the stored count is at least `DEPTH - af_ofs_i`.
- R9: If `wen2_ld` is high during reset, the block is in dual-enable mode. A cycle with `wen1_n` low and `wen2_ld` low then stores nothing, and `ofs_wr_o` stays low.
- R10: If `wen2_ld` is low during reset, the block is in programmable-flag mode. A cycle with `wen1_n` low and `wen2_ld` low then raises `ofs_wr_o` combinationally in that cycle and stores nothing.
- R11: `rdata_vld_o` is the inverse of `oe_n`.
- R12: After a single write into an empty buffer, `empty_n` rises within 6 read-clock cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Write clock |
| rclk | input | 1 | Read clock |
| rst_n | input | 1 | Active-low reset, shared by both sides |
| wen1_n | input | 1 | Active-low write enable |
| wen2_ld | input | 1 | Second write enable, or load select; sampled as mode while reset is low |
| wdata_i | input | DATA_W | Write data |
| ae_ofs_i | input | $clog2(DEPTH)+1 | Almost-empty threshold |
| af_ofs_i | input | $clog2(DEPTH)+1 | Almost-full threshold |
| ren1_n | input | 1 | Active-low read enable, first |
| ren2_n | input | 1 | Active-low read enable, second |
| oe_n | input | 1 | Active-low output enable |
| rdata_o | output | DATA_W | Output register |
| rdata_vld_o | output | 1 | Output data qualifier |
| empty_n | output | 1 | Empty flag, read clock |
| aempty_n | output | 1 | Almost-empty flag, read clock |
| full_n | output | 1 | Full flag, write clock |
| afull_n | output | 1 | Almost-full flag, write clock |
| ofs_wr_o | output | 1 | Offset-write strobe to the loading block |

## Verification
The bench builds the block with its default `DEPTH` of 64 and a 9-bit word. Filling the buffer then takes only a few hundred cycles, so the full boundary is reached, as are both almost thresholds (the defaults of 7 and the changed values 20 and 10). A streaming phase runs more than twice the depth through the buffer, which carries both pointers past the point where they wrap. The write clock runs at 5 ns and the read clock at 7 ns. Because the two are unrelated, the Gray-code crossing is exercised at many different phase offsets.

// File: rtl/dcf_pkg.sv
package dcf_pkg;
  typedef logic [15:0] ptr_t;

  function automatic ptr_t bin2gray(ptr_t b);
    return b ^ (b >> 1);
  endfunction

  function automatic ptr_t gray2bin(ptr_t g);
    ptr_t b;
    b[15] = g[15];
    for (int i = 14; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  // Stored words between a leading and a trailing position (modular).
  function automatic ptr_t level(ptr_t lead, ptr_t trail);
    return lead - trail;
  endfunction
endpackage

// File: rtl/dcf_sync.sv
module dcf_sync #(
  parameter int W      = 8,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [STAGES-1:0][W-1:0] stg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stg <= '0;
    end else begin
      stg[0] <= d;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/dcf_mem.sv
module dcf_mem #(
  parameter int DW    = 9,
  parameter int DEPTH = 64,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          wclk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] store [DEPTH];

  always_ff @(posedge wclk) begin
    if (we) store[waddr] <= wdata;
  end

  assign rdata = store[raddr];
endmodule

// File: rtl/dcf_wr_ctl.sv
module dcf_wr_ctl #(
  parameter int DEPTH = 64,
  localparam int AW   = $clog2(DEPTH),
  localparam int PW   = AW + 1
) (
  input  logic          wclk,
  input  logic          rst_n,
  input  logic          wen1_n,
  input  logic          wen2_ld,
  input  logic [PW-1:0] rgray_s,
  input  logic [PW-1:0] af_ofs,
  output logic          we,
  output logic [AW-1:0] waddr,
  output logic [PW-1:0] wgray,
  output logic          full_n,
  output logic          afull_n,
  output logic          ofs_wr
);
  import dcf_pkg::*;
  localparam logic [PW-1:0] DEPTH_P = PW'(DEPTH);

  logic          mode_dual_q, live_q, full_q, afull_q;
  logic [PW-1:0] wbin_q, wbin_nxt, rbin_w, lvl_nxt, lvl_now;
  logic          wr_req, wr_fire;

  // Mode latch: follows the pin on every write-clock edge while reset is low.
  always_ff @(posedge wclk) begin
    if (!rst_n) mode_dual_q <= wen2_ld;
  end

  always_ff @(posedge wclk or negedge rst_n) begin
    if (!rst_n) live_q <= 1'b0;
    else        live_q <= 1'b1;
  end

  assign wr_req   = live_q && !wen1_n && wen2_ld;
  assign wr_fire  = wr_req && !full_q;
  assign ofs_wr   = live_q && !mode_dual_q && !wen1_n && !wen2_ld;
  assign rbin_w   = PW'(gray2bin(16'(rgray_s)));
  assign wbin_nxt = wbin_q + PW'(wr_fire);
  assign lvl_nxt  = PW'(level(16'(wbin_nxt), 16'(rbin_w)));
  assign lvl_now  = PW'(level(16'(wbin_q), 16'(rbin_w)));

  always_ff @(posedge wclk or negedge rst_n) begin
    if (!rst_n) begin
      wbin_q  <= '0;
      wgray   <= '0;
      full_q  <= 1'b0;
      afull_q <= 1'b0;
    end else begin
      wbin_q  <= wbin_nxt;
      wgray   <= PW'(bin2gray(16'(wbin_nxt)));
      full_q  <= (lvl_nxt == DEPTH_P);
      afull_q <= (lvl_nxt >= DEPTH_P - af_ofs);
    end
  end

  assign we      = wr_fire;
  assign waddr   = wbin_q[AW-1:0];
  assign full_n  = !full_q;
  assign afull_n = !afull_q;

  AST_NO_OVERFLOW: assert property (@(posedge wclk) disable iff (!rst_n)
    lvl_now <= DEPTH_P); // R4
  AST_FULL_BLOCKS: assert property (@(posedge wclk) disable iff (!rst_n)
    !full_n |=> $stable(wbin_q)); // R4
  AST_FULL_IN_AFULL: assert property (@(posedge wclk) disable iff (!rst_n)
    !full_n |-> !afull_n); // R8
  AST_LOAD_NO_STORE: assert property (@(posedge wclk) disable iff (!rst_n)
    ofs_wr |=> $stable(wbin_q)); // R10
  AST_WGRAY_STEP: assert property (@(posedge wclk) disable iff (!rst_n)
    $countones(wgray ^ $past(wgray)) <= 1); // R12
endmodule

// File: rtl/dcf_rd_ctl.sv
module dcf_rd_ctl #(
  parameter int DW    = 9,
  parameter int DEPTH = 64,
  localparam int AW   = $clog2(DEPTH),
  localparam int PW   = AW + 1
) (
  input  logic          rclk,
  input  logic          rst_n,
  input  logic          ren1_n,
  input  logic          ren2_n,
  input  logic [PW-1:0] wgray_s,
  input  logic [PW-1:0] ae_ofs,
  input  logic [DW-1:0] mem_rdata,
  output logic [AW-1:0] raddr,
  output logic [PW-1:0] rgray,
  output logic [DW-1:0] rdata,
  output logic          empty_n,
  output logic          aempty_n
);
  import dcf_pkg::*;

  logic          empty_q, aempty_q, rd_fire;
  logic [PW-1:0] rbin_q, rbin_nxt, wbin_r, lvl_nxt;

  assign rd_fire  = !ren1_n && !ren2_n && !empty_q;
  assign wbin_r   = PW'(gray2bin(16'(wgray_s)));
  assign rbin_nxt = rbin_q + PW'(rd_fire);
  assign lvl_nxt  = PW'(level(16'(wbin_r), 16'(rbin_nxt)));

  always_ff @(posedge rclk or negedge rst_n) begin
    if (!rst_n) begin
      rbin_q   <= '0;
      rgray    <= '0;
      empty_q  <= 1'b1;
      aempty_q <= 1'b1;
      rdata    <= '0;
    end else begin
      rbin_q   <= rbin_nxt;
      rgray    <= PW'(bin2gray(16'(rbin_nxt)));
      empty_q  <= (lvl_nxt == '0);
      aempty_q <= (lvl_nxt <= ae_ofs);
      if (rd_fire) rdata <= mem_rdata;
    end
  end

  assign raddr    = rbin_q[AW-1:0];
  assign empty_n  = !empty_q;
  assign aempty_n = !aempty_q;

  AST_EMPTY_BLOCKS: assert property (@(posedge rclk) disable iff (!rst_n)
    !empty_n |=> ($stable(rbin_q) && $stable(rdata))); // R5
  AST_HOLD_OUTPUT: assert property (@(posedge rclk) disable iff (!rst_n)
    (ren1_n || ren2_n) |=> $stable(rdata)); // R3
  AST_EMPTY_IN_AEMPTY: assert property (@(posedge rclk) disable iff (!rst_n)
    !empty_n |-> !aempty_n); // R7
  AST_RGRAY_STEP: assert property (@(posedge rclk) disable iff (!rst_n)
    $countones(rgray ^ $past(rgray)) <= 1); // R12
endmodule

// File: rtl/dcf_pflag_top.sv
module dcf_pflag_top #(
  parameter int DATA_W = 9,
  parameter int DEPTH  = 64,
  localparam int AW    = $clog2(DEPTH),
  localparam int PW    = AW + 1
) (
  input  logic              wclk,
  input  logic              rclk,
  input  logic              rst_n,
  input  logic              wen1_n,
  input  logic              wen2_ld,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [PW-1:0]     ae_ofs_i,
  input  logic [PW-1:0]     af_ofs_i,
  input  logic              ren1_n,
  input  logic              ren2_n,
  input  logic              oe_n,
  output logic [DATA_W-1:0] rdata_o,
  output logic              rdata_vld_o,
  output logic              empty_n,
  output logic              aempty_n,
  output logic              full_n,
  output logic              afull_n,
  output logic              ofs_wr_o
);
  logic              we;
  logic [AW-1:0]     waddr, raddr;
  logic [PW-1:0]     wgray, rgray, wgray_s, rgray_s;
  logic [DATA_W-1:0] mem_rdata;

  dcf_wr_ctl #(.DEPTH(DEPTH)) u_wr (
    .wclk(wclk), .rst_n(rst_n), .wen1_n(wen1_n), .wen2_ld(wen2_ld),
    .rgray_s(rgray_s), .af_ofs(af_ofs_i), .we(we), .waddr(waddr),
    .wgray(wgray), .full_n(full_n), .afull_n(afull_n), .ofs_wr(ofs_wr_o)
  );

  dcf_sync #(.W(PW), .STAGES(2)) u_r2w (
    .clk(wclk), .rst_n(rst_n), .d(rgray), .q(rgray_s)
  );

  dcf_sync #(.W(PW), .STAGES(2)) u_w2r (
    .clk(rclk), .rst_n(rst_n), .d(wgray), .q(wgray_s)
  );

  dcf_mem #(.DW(DATA_W), .DEPTH(DEPTH)) u_mem (
    .wclk(wclk), .we(we), .waddr(waddr), .wdata(wdata_i),
    .raddr(raddr), .rdata(mem_rdata)
  );

  dcf_rd_ctl #(.DW(DATA_W), .DEPTH(DEPTH)) u_rd (
    .rclk(rclk), .rst_n(rst_n), .ren1_n(ren1_n), .ren2_n(ren2_n),
    .wgray_s(wgray_s), .ae_ofs(ae_ofs_i), .mem_rdata(mem_rdata),
    .raddr(raddr), .rgray(rgray), .rdata(rdata_o),
    .empty_n(empty_n), .aempty_n(aempty_n)
  );

  assign rdata_vld_o = !oe_n;

  AST_OE_QUAL: assert property (@(posedge rclk) rdata_vld_o == !oe_n); // R11
endmodule

// File: tb/dcf_pflag_top_tb_top.sv
`timescale 1ns/1ps
module dcf_pflag_top_tb_top;
  localparam int DW    = 9;
  localparam int DEPTH = 64;
  localparam int PW    = $clog2(DEPTH) + 1;

  logic wclk = 0, rclk = 0, rst_n = 0;
  logic wen1_n = 1, wen2_ld = 1, ren1_n = 1, ren2_n = 1, oe_n = 1;
  logic [DW-1:0] wdata = '0;
  logic [PW-1:0] ae_ofs = PW'(7), af_ofs = PW'(7);
  logic [DW-1:0] rdata;
  logic rdata_vld, empty_n, aempty_n, full_n, afull_n, ofs_wr;

  int nchk = 0, nerr = 0, wcyc = 0;
  bit done = 0;
  logic [DW-1:0] model_q [$];
  logic [DW-1:0] exp_rdata = '0;

  always #2.5 wclk = ~wclk;
  always #3.5 rclk = ~rclk;

  dcf_pflag_top #(.DATA_W(DW), .DEPTH(DEPTH)) dut_i (
    .wclk(wclk), .rclk(rclk), .rst_n(rst_n), .wen1_n(wen1_n), .wen2_ld(wen2_ld),
    .wdata_i(wdata), .ae_ofs_i(ae_ofs), .af_ofs_i(af_ofs), .ren1_n(ren1_n),
    .ren2_n(ren2_n), .oe_n(oe_n), .rdata_o(rdata), .rdata_vld_o(rdata_vld),
    .empty_n(empty_n), .aempty_n(aempty_n), .full_n(full_n), .afull_n(afull_n),
    .ofs_wr_o(ofs_wr)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // Write-side model: a word is accepted when R1's condition holds.
  always @(negedge wclk) begin
    if (rst_n) begin
      chk(!(full_n && model_q.size() >= DEPTH), "R4 full_n high with buffer full",
          int'(full_n), 0);
      if (!wen1_n && wen2_ld && full_n) model_q.push_back(wdata);
    end
  end

  // Read-side model: compare the output register every read clock.
  always @(negedge rclk) begin
    if (!rst_n) begin
      exp_rdata = '0;
    end else begin
      chk(rdata === exp_rdata, "R2 R3 output word", int'(rdata), int'(exp_rdata));
      chk(!(empty_n && model_q.size() == 0), "R5 empty_n high with buffer empty",
          int'(empty_n), 0);
      if (!ren1_n && !ren2_n && empty_n && model_q.size() > 0)
        exp_rdata = model_q.pop_front();
    end
  end

  always @(posedge wclk) begin
    wcyc++;
    if (wcyc > 150000 && !done) begin
      nerr++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  end

  task automatic do_reset(input logic mode_pin);
    @(posedge wclk); #1;
    wen1_n = 1; ren1_n = 1; ren2_n = 1; wen2_ld = mode_pin;
    rst_n = 0;
    model_q.delete();
    repeat (4) @(posedge wclk);
    repeat (2) @(posedge rclk);
    @(negedge wclk);
    rst_n = 1;
    @(posedge wclk); #1;
    wen2_ld = 1;
    repeat (2) @(posedge wclk);
  endtask

  task automatic write_n(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge wclk); #1;
      wen1_n = 0; wen2_ld = 1; wdata = DW'($urandom);
    end
    @(posedge wclk); #1;
    wen1_n = 1;
  endtask

  task automatic read_n(input int n, input bit hold2);
    for (int i = 0; i < n; i++) begin
      @(posedge rclk); #1;
      ren1_n = 0; ren2_n = hold2;
    end
    @(posedge rclk); #1;
    ren1_n = 1; ren2_n = 1;
  endtask

  task automatic drain();
    for (int i = 0; i < 4000 && (model_q.size() > 0 || empty_n); i++) begin
      @(posedge rclk); #1;
      ren1_n = 0; ren2_n = 0;
    end
    read_n(6, 0);
  endtask

  task automatic settle();
    repeat (10) @(posedge rclk);
    repeat (10) @(posedge wclk);
    @(negedge wclk);
  endtask

  task automatic check_flags(input string tag);
    int n = model_q.size();
    chk(empty_n  == (n != 0), {tag, " R5 empty_n"}, int'(empty_n), int'(n != 0));
    chk(aempty_n == !(n <= int'(ae_ofs)), {tag, " R7 aempty_n"}, int'(aempty_n),
        int'(!(n <= int'(ae_ofs))));
    chk(full_n   == (n != DEPTH), {tag, " R4 full_n"}, int'(full_n), int'(n != DEPTH));
    chk(afull_n  == !(n >= DEPTH - int'(af_ofs)), {tag, " R8 afull_n"}, int'(afull_n),
        int'(!(n >= DEPTH - int'(af_ofs))));
  endtask

  initial begin
    int lat;
    do_reset(1'b1);
    // R6 reset state
    @(negedge rclk);
    chk(empty_n == 0 && aempty_n == 0, "R6 read flags after reset", int'({empty_n, aempty_n}), 0);
    chk(full_n == 1 && afull_n == 1, "R6 write flags after reset", int'({full_n, afull_n}), 3);
    chk(rdata == 0, "R6 output register after reset", int'(rdata), 0);
    // R11 output qualifier
    chk(rdata_vld == 0, "R11 vld with oe_n high", int'(rdata_vld), 0);
    oe_n = 0; #1;
    chk(rdata_vld == 1, "R11 vld with oe_n low", int'(rdata_vld), 1);

    // R9: dual mode, second enable low blocks the write and raises no strobe
    @(posedge wclk); #1;
    wen1_n = 0; wen2_ld = 0;
    @(negedge wclk);
    chk(ofs_wr == 0, "R9 no offset strobe in dual mode", int'(ofs_wr), 0);
    @(posedge wclk); #1;
    wen1_n = 1; wen2_ld = 1;
    settle();
    chk(empty_n == 0, "R9 nothing stored with wen2 low", int'(empty_n), 0);

    // R7 with default threshold 7
    write_n(5); settle(); check_flags("five words");
    write_n(3); settle(); check_flags("eight words");
    // R3: second read enable high, nothing moves
    read_n(5, 1); settle(); check_flags("after held reads");
    // R4/R8: overfill
    write_n(70); settle(); check_flags("full");
    chk(model_q.size() == DEPTH, "R4 overfill ignored", model_q.size(), DEPTH);
    // R2/R5: drain then read past empty
    drain(); settle(); check_flags("drained");
    read_n(4, 0); settle(); check_flags("reads on empty");

    // Streaming across pointer wrap
    fork
      write_n(300);
      read_n(420, 0);
    join
    drain(); settle(); check_flags("after stream");

    // R12 crossing latency
    @(posedge wclk); #1; wen1_n = 0; wdata = 9'h1a5;
    @(posedge wclk); #1; wen1_n = 1;
    lat = 0;
    while (!empty_n && lat < 20) begin @(posedge rclk); lat++; end
    #1;
    chk(lat <= 6, "R12 empty_n rise latency", lat, 6);
    drain(); settle();

    // Programmable-flag mode; R6 output clear on reset
    chk(rdata != 0, "R2 nonzero word before reset", int'(rdata), 421);
    do_reset(1'b0);
    @(negedge rclk);
    chk(rdata == 0, "R6 output cleared by reset", int'(rdata), 0);
    @(posedge wclk); #1;
    wen1_n = 0; wen2_ld = 0;
    @(negedge wclk);
    chk(ofs_wr == 1, "R10 offset strobe with load low", int'(ofs_wr), 1);
    @(posedge wclk); #1;
    wen1_n = 1; wen2_ld = 1;
    @(negedge wclk);
    chk(ofs_wr == 0, "R10 strobe drops with wen1 high", int'(ofs_wr), 0);
    settle();
    chk(empty_n == 0, "R10 load cycle stored nothing", int'(empty_n), 0);

    // Changed thresholds (R1 in this mode is covered by the output model)
    ae_ofs = PW'(20); af_ofs = PW'(10);
    write_n(20); settle(); check_flags("twenty words");
    write_n(1);  settle(); check_flags("twenty-one words");
    write_n(33); settle(); check_flags("fifty-four words");
    read_n(1, 0); settle(); check_flags("fifty-three words");
    chk(model_q.size() == 53, "R1 word count in flag mode", model_q.size(), 53);
    drain(); settle(); check_flags("final");

    done = 1;
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule